// File: doc/BRIEF.md
# I2C slave address detector

This block is the address-recognition front end of an I2C target. It watches the two-wire bus through metastability synchronizers and finds start and stop conditions. It keeps a bus-busy flag up between them and shifts in the first byte that follows every start, most significant bit first. When the upper seven bits of that byte equal the programmed own address, it raises an addressed flag and pulls SDA low through the ninth clock pulse as the acknowledge. It also latches the direction bit from the byte's least significant bit.

When the address does not match, the block never drives SDA. It then waits for the next start or stop. Data bytes after the address, clock stretching, general call and 10-bit addressing are handled elsewhere. The SDA output is an open-drain enable: a 1 means pull the line low, and the pad or board supplies the pull-up.

Top module: `i2c_addr_detect`

## Requirements
- R1: After reset, busy_o, addressed_o, tx_dir_o and sda_oe_o are all 0.
- R2: A start condition is SDA falling while SCL is high. It sets busy_o to 1 and clears addressed_o and tx_dir_o to 0. This also holds for a repeated start while the block is addressed.
- R3: A stop condition is SDA rising while SCL is high. It clears busy_o and addressed_o to 0.
- R4: The eight bits after a start are sampled on SCL rising edges and shifted in MSB first. After the eighth bit, rx_byte_o holds the received byte, with bit 7 being the first bit on the bus.
- R5: If rx_byte_o[7:1] equals own_addr_i, addressed_o goes to 1 on the SCL falling edge that ends the eighth bit.
- R6: On a match, tx_dir_o is loaded with rx_byte_o[0]: 1 for a master read, 0 for a master write.
- R7: On a match, sda_oe_o is 1 from the SCL falling edge after the eighth bit until the SCL falling edge that ends the ninth bit. The master therefore sees SDA low while SCL is high in the ninth bit.
- R8: On a mismatch, sda_oe_o stays 0 and addressed_o and tx_dir_o stay 0 until the next start or stop. Later bytes are not acknowledged.
- R9: A repeated start in the middle of an address byte discards the partial byte. The next eight bits are taken as a fresh address.
- R10: After the acknowledge is released, later bytes in the same transfer are not acknowledged and do not change addressed_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| own_addr_i | input | 7 | Programmed own 7-bit address |
| sda_oe_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| busy_o | output | 1 | Bus busy between start and stop |
| addressed_o | output | 1 | Addressed as a target by the last address byte |
| tx_dir_o | output | 1 | Direction bit of the matched address (1 = target transmits) |
| rx_byte_o | output | 8 | Shift register holding the received address byte |

## Verification
Start detection and the address engine can act in the same clock cycle. A start may arrive while a byte is half shifted, or while a previous match still holds addressed_o and tx_dir_o. The bench provokes both cases. It issues a repeated start after three bits, and a repeated start right after a read-direction match. The start must win in both cases: the flags must clear, busy_o must stay set, and the following full byte must be decoded and acknowledged as a fresh address.

// File: rtl/i2cad_pkg.sv
package i2cad_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_ACK  = 2'd2,
    ST_WAIT = 2'd3
  } det_state_e;

endpackage

// File: rtl/i2cad_sync.sv
module i2cad_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES > 1) begin : g_chain
      assign stg_d = {stg_q[STAGES-2:0], d_i};
    end else begin : g_single
      assign stg_d = d_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/i2cad_cond.sv
module i2cad_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);

  logic scl_q, sda_q;

  // previous synchronized levels; bus idles high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  always_comb begin
    start_o    = scl_q & scl_s_i & sda_q & ~sda_s_i;
    stop_o     = scl_q & scl_s_i & ~sda_q & sda_s_i;
    scl_rise_o = ~scl_q & scl_s_i;
    scl_fall_o = scl_q & ~scl_s_i;
  end

endmodule

// File: rtl/i2cad_ctrl.sv
module i2cad_ctrl
  import i2cad_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_s_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic              addressed_o,
  output logic              tx_dir_o,
  output logic [ADDR_W:0]   rx_byte_o
);

  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  det_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTE_W-1:0]  shift_q, shift_d;
  logic               busy_q, busy_d;
  logic               hit_q, hit_d;
  logic               dir_q, dir_d;
  logic               oe_q, oe_d;
  logic               byte_full;
  logic               addr_match;

  assign byte_full  = (cnt_q == CNT_FULL);
  assign addr_match = (shift_q[BYTE_W-1:1] == own_addr_i);

  // next-state logic: bus conditions take priority over the byte engine
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    busy_d  = busy_q;
    hit_d   = hit_q;
    dir_d   = dir_q;
    oe_d    = oe_q;
    if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      shift_d = '0;
      busy_d  = 1'b1;
      hit_d   = 1'b0;
      dir_d   = 1'b0;
      oe_d    = 1'b0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      busy_d  = 1'b0;
      hit_d   = 1'b0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise_i && !byte_full) begin
            shift_d = {shift_q[BYTE_W-2:0], sda_s_i};
            cnt_d   = cnt_q + 1'b1;
          end else if (scl_fall_i && byte_full) begin
            if (addr_match) begin
              hit_d   = 1'b1;
              dir_d   = shift_q[0];
              oe_d    = 1'b1;
              state_d = ST_ACK;
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            oe_d    = 1'b0;
            state_d = ST_WAIT;
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      busy_q  <= 1'b0;
      hit_q   <= 1'b0;
      dir_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      busy_q  <= busy_d;
      hit_q   <= hit_d;
      dir_q   <= dir_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe_o    = oe_q;
  assign busy_o      = busy_q;
  assign addressed_o = hit_q;
  assign tx_dir_o    = dir_q;
  assign rx_byte_o   = shift_q;

endmodule

// File: rtl/i2c_addr_detect.sv
module i2c_addr_detect #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic              addressed_o,
  output logic              tx_dir_o,
  output logic [ADDR_W:0]   rx_byte_o
);

  localparam int NUM_LINES = 2;

  logic [1:0]           rst_pipe_q;
  logic                 rst_sync_n;
  logic [NUM_LINES-1:0] line_raw;
  logic [NUM_LINES-1:0] line_s;
  logic                 scl_s, sda_s;
  logic                 start_w, stop_w, scl_rise_w, scl_fall_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
    i2cad_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
    ) sync_i (
      .clk_i (clk_i),
      .rst_ni(rst_sync_n),
      .d_i   (line_raw[g]),
      .q_o   (line_s[g])
    );
  end

  assign scl_s = line_s[0];
  assign sda_s = line_s[1];

  i2cad_cond cond_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .start_o   (start_w),
    .stop_o    (stop_w),
    .scl_rise_o(scl_rise_w),
    .scl_fall_o(scl_fall_w)
  );

  i2cad_ctrl #(
    .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .scl_rise_i (scl_rise_w),
    .scl_fall_i (scl_fall_w),
    .sda_s_i    (sda_s),
    .own_addr_i (own_addr_i),
    .sda_oe_o   (sda_oe_o),
    .busy_o     (busy_o),
    .addressed_o(addressed_o),
    .tx_dir_o   (tx_dir_o),
    .rx_byte_o  (rx_byte_o)
  );

endmodule

// File: rtl/i2cad_chk.sv
module i2cad_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic start_w,
  input logic stop_w,
  input logic sda_oe_o,
  input logic busy_o,
  input logic addressed_o,
  input logic tx_dir_o
);

  assert_oe_needs_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> addressed_o);

  assert_addressed_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addressed_o |-> busy_o);

  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> (busy_o && !addressed_o && !tx_dir_o));

  assert_stop_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> (!busy_o && !addressed_o && !sda_oe_o));

  // the acknowledge drive only starts while SCL is low (R8: no SDA drive otherwise)
  assert_oe_rise_scl_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_s));

  assert_oe_release_scl_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sda_oe_o) && !$past(start_w) && !$past(stop_w)) |-> !$past(scl_s));

endmodule

bind i2c_addr_detect i2cad_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_sync_n),
  .scl_s      (scl_s),
  .start_w    (start_w),
  .stop_w     (stop_w),
  .sda_oe_o   (sda_oe_o),
  .busy_o     (busy_o),
  .addressed_o(addressed_o),
  .tx_dir_o   (tx_dir_o)
);

// File: tb/i2c_addr_detect_tb_top.sv
`timescale 1ns/1ps
module i2c_addr_detect_tb_top;

  localparam int Q = 12;  // quarter SCL period in system clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_drv = 1'b1;
  logic       sda_drv = 1'b1;
  logic [6:0] own = 7'h3A;
  logic       sda_line;
  logic       sda_oe, busy, addressed, tx_dir;
  logic [7:0] rx_byte;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  assign sda_line = sda_drv & ~sda_oe;  // open-drain wired AND

  i2c_addr_detect dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_drv),
    .sda_i      (sda_line),
    .own_addr_i (own),
    .sda_oe_o   (sda_oe),
    .busy_o     (busy),
    .addressed_o(addressed),
    .tx_dir_o   (tx_dir),
    .rx_byte_o  (rx_byte)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_drv = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b0; tick(Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_drv = 1'b0; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b1; tick(Q);
  endtask

  task automatic bus_bit(input logic b);
    sda_drv = b; tick(Q);
    scl_drv = 1'b1; tick(2 * Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  // eight bits then the ninth pulse with SDA released; returns 1 if acknowledged
  task automatic bus_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    sda_drv = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic t_reset;
    chk("R1", "busy", busy, 0);
    chk("R1", "addressed", addressed, 0);
    chk("R1", "tx_dir", tx_dir, 0);
    chk("R1", "sda_oe", sda_oe, 0);
  endtask

  task automatic t_match_write;
    logic ack;
    bus_start;
    chk("R2", "busy after start", busy, 1);
    bus_byte({own, 1'b0}, ack);
    chk("R4", "rx_byte write", rx_byte, {own, 1'b0});
    chk("R5", "addressed write", addressed, 1);
    chk("R6", "tx_dir write", tx_dir, 0);
    chk("R7", "ack seen", ack, 1);
    chk("R7", "sda released after 9th", sda_oe, 0);
    bus_byte(8'hFF, ack);
    chk("R10", "data byte ack", ack, 0);
    chk("R10", "addressed kept", addressed, 1);
    bus_stop;
    chk("R3", "busy after stop", busy, 0);
    chk("R3", "addressed after stop", addressed, 0);
  endtask

  task automatic t_match_read_restart;
    logic ack;
    bus_start;
    bus_byte({own, 1'b1}, ack);
    chk("R6", "tx_dir read", tx_dir, 1);
    chk("R7", "ack read", ack, 1);
    bus_start;  // repeated start while addressed
    chk("R2", "busy on restart", busy, 1);
    chk("R2", "addressed cleared", addressed, 0);
    chk("R2", "tx_dir cleared", tx_dir, 0);
    bus_stop;
  endtask

  task automatic t_mismatch;
    logic ack;
    bus_start;
    bus_byte(8'h2B, ack);  // upper bits 0x15 != 0x3A
    chk("R4", "rx_byte mismatch", rx_byte, 8'h2B);
    chk("R8", "no ack", ack, 0);
    chk("R8", "addressed", addressed, 0);
    chk("R8", "tx_dir", tx_dir, 0);
    chk("R8", "sda_oe", sda_oe, 0);
    bus_byte({own, 1'b0}, ack);  // own address as data: must stay ignored
    chk("R8", "later byte ack", ack, 0);
    chk("R8", "addressed later", addressed, 0);
    bus_stop;
  endtask

  task automatic t_restart_mid;
    logic ack;
    bus_start;
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    bus_start;
    chk("R9", "busy kept", busy, 1);
    bus_byte({own, 1'b1}, ack);
    chk("R9", "rx_byte fresh", rx_byte, {own, 1'b1});
    chk("R9", "ack fresh", ack, 1);
    chk("R9", "addressed fresh", addressed, 1);
    bus_stop;
  endtask

  task automatic t_new_addr;
    logic ack;
    own = 7'h7F;
    tick(Q);
    bus_start;
    bus_byte(8'hFE, ack);
    chk("R5", "addressed 0x7F", addressed, 1);
    chk("R7", "ack 0x7F", ack, 1);
    bus_stop;
    own = 7'h00;
    tick(Q);
    bus_start;
    bus_byte(8'h01, ack);
    chk("R5", "addressed 0x00", addressed, 1);
    chk("R6", "tx_dir 0x00 read", tx_dir, 1);
    bus_stop;
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset;
    t_match_write;
    t_match_read_restart;
    t_mismatch;
    t_restart_mid;
    t_new_addr;
    tick(10);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(150000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule